// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the combinational control core for a five-stage in-order integer pipeline with fetch, decode, execute, memory and writeback stages. Each cycle it looks at the register indices, write enables and load flag held in the three downstream pipeline registers. It also looks at the execute-stage redirect indication raised by a taken branch or a jump. From these it decides two things for each ALU operand: whether the operand comes from the register file or is bypassed from a later stage. It also decides whether fetch and decode must hold, and which stages must be squashed or filled with a bubble.

A memory-not-ready input freezes every pipeline register and inserts no bubble. A few flip-flops after reset form a delay chain that keeps trap reporting masked until the pipeline has filled with defined contents. The ALU, register file, branch comparator and memories sit outside the block. The surrounding pipeline wires the enable, bubble and flush outputs into its stage registers.

Top module: `hz_unit`

## Requirements
- R1: For each operand (fwd_a for the first source, fwd_b for the second), select code 01 (EX/MEM result) is given when the EX/MEM stage writes a nonzero destination equal to that execute-stage source. This holds even if MEM/WB also matches.
- R2: Select code 10 (MEM/WB value) is given when R1 does not apply and the MEM/WB stage writes a nonzero destination equal to the source.
- R3: Otherwise the select is 00 (register file). A destination of x0 never produces code 01 or 10.
- R4: Consider a load in execute with write enable set and a nonzero destination equal to either decode-stage source, with no redirect and no memory wait. Then pc_en=0, ifid_en=0, pipe_en=1 and idex_bubble=1, with both flushes 0.
- R5: With no memory wait and no redirect, these cases cause no stall: a load whose destination is x0, a non-load, and a load with no matching source. The outputs are pc_en=1, ifid_en=1, pipe_en=1, and bubble and flushes 0.
- R6: A redirect from execute with no memory wait sets ifid_flush=1 and idex_flush=1 with pc_en=ifid_en=pipe_en=1 and idex_bubble=0. This holds even when a load-use hazard is present.
- R7: While mem_busy=1, pc_en, ifid_en, pipe_en, idex_bubble, ifid_flush and idex_flush are all 0. The forwarding selects are still computed as in R1 to R3.
- R8: trap_out is 0 until TRAP_DLY (default 3) rising clock edges have occurred after rst_n goes high. From then on, trap_out equals trap_raw.
- R9: While rst_n is low, trap_out is 0 regardless of trap_raw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | REG_AW | First source index of the instruction in decode |
| id_rs2 | input | REG_AW | Second source index of the instruction in decode |
| ex_rs1 | input | REG_AW | First source index in ID/EX |
| ex_rs2 | input | REG_AW | Second source index in ID/EX |
| ex_rd | input | REG_AW | Destination index in ID/EX |
| ex_we | input | 1 | ID/EX writes a register |
| ex_load | input | 1 | ID/EX holds a load |
| mem_rd | input | REG_AW | Destination index in EX/MEM |
| mem_we | input | 1 | EX/MEM writes a register |
| wb_rd | input | REG_AW | Destination index in MEM/WB |
| wb_we | input | 1 | MEM/WB writes a register |
| ex_redirect | input | 1 | Taken branch or jump resolved in execute |
| mem_busy | input | 1 | Memory not ready, freeze pipeline |
| trap_raw | input | 1 | Unmasked trap indication |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| pc_en | output | 1 | PC load enable |
| ifid_en | output | 1 | IF/ID register enable |
| pipe_en | output | 1 | Enable for ID/EX, EX/MEM and MEM/WB |
| idex_bubble | output | 1 | Load a bubble into ID/EX |
| ifid_flush | output | 1 | Squash the instruction entering IF/ID |
| idex_flush | output | 1 | Squash the instruction entering ID/EX |
| trap_out | output | 1 | Trap indication after the reset mask |

## Verification
Random register indices are drawn from a small range, so the destinations of the three stages often coincide with the sources or with x0. These draws show which forwarding priority applies and that x0 is excluded. Random load, redirect and wait flags mix stall, flush and freeze conditions, which shows the ordering freeze over flush over stall. Directed cases cover a match at both stages, a load to x0, a redirect together with a load-use hazard, and a redirect during a wait. A walk through the cycles after reset release shows the exact edge on which trap reporting opens.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  output fwd_sel_e          sel
);
  localparam logic [REG_AW-1:0] ZERO = '0;

  logic hit_mem, hit_wb;

  always_comb begin
    hit_mem = mem_we && (mem_rd != ZERO) && (mem_rd == src);
    hit_wb  = wb_we  && (wb_rd  != ZERO) && (wb_rd  == src);
    if (hit_mem)     sel = FWD_MEM;
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  // R3
  x0_never_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == ZERO) |-> (sel == FWD_RF));
  // R1
  younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wb_we && mem_rd == wb_rd && mem_rd == src && src != ZERO)
      |-> (sel == FWD_MEM));
endmodule

// File: rtl/hz_pipe_ctl.sv
module hz_pipe_ctl #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_we,
  input  logic              ex_load,
  input  logic              ex_redirect,
  input  logic              mem_busy,
  output logic              pc_en,
  output logic              ifid_en,
  output logic              pipe_en,
  output logic              idex_bubble,
  output logic              ifid_flush,
  output logic              idex_flush
);
  localparam logic [REG_AW-1:0] ZERO = '0;

  logic load_use;

  always_comb begin
    load_use = ex_load && ex_we && (ex_rd != ZERO) &&
               ((ex_rd == id_rs1) || (ex_rd == id_rs2));
    pc_en       = 1'b1;
    ifid_en     = 1'b1;
    pipe_en     = 1'b1;
    idex_bubble = 1'b0;
    ifid_flush  = 1'b0;
    idex_flush  = 1'b0;
    if (mem_busy) begin
      pc_en   = 1'b0;
      ifid_en = 1'b0;
      pipe_en = 1'b0;
    end else if (ex_redirect) begin
      ifid_flush = 1'b1;
      idex_flush = 1'b1;
    end else if (load_use) begin
      pc_en       = 1'b0;
      ifid_en     = 1'b0;
      idex_bubble = 1'b1;
    end
  end

  // R7
  freeze_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy |-> (!pc_en && !ifid_en && !pipe_en && !idex_bubble && !ifid_flush && !idex_flush));
  // R6
  flush_beats_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idex_flush |-> (!idex_bubble && pc_en));
  // R4
  stall_holds_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!pc_en && !ifid_en && pipe_en));
  // R5
  x0_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == ZERO) |-> !idex_bubble);
endmodule

// File: rtl/hz_trap_gate.sv
module hz_trap_gate #(
  parameter int TRAP_DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_raw,
  output logic trap_out
);
  logic [TRAP_DLY-1:0] chain_q, chain_d;
  logic                armed;

  always_comb begin
    chain_d = {chain_q[TRAP_DLY-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  always_comb begin
    armed    = chain_q[TRAP_DLY-1];
    trap_out = trap_raw && armed;
  end

  // R8
  masked_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !trap_out);
  // R8
  armed_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int REG_AW   = 5,
  parameter int TRAP_DLY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_we,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  input  logic              ex_redirect,
  input  logic              mem_busy,
  input  logic              trap_raw,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              pc_en,
  output logic              ifid_en,
  output logic              pipe_en,
  output logic              idex_bubble,
  output logic              ifid_flush,
  output logic              idex_flush,
  output logic              trap_out
);
  localparam int NOPS = 2;

  logic [REG_AW-1:0] op_src [NOPS];
  fwd_sel_e          op_sel [NOPS];

  assign op_src[0] = ex_rs1;
  assign op_src[1] = ex_rs2;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hz_fwd_sel #(.REG_AW(REG_AW)) u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (op_src[g]),
      .mem_rd (mem_rd),
      .mem_we (mem_we),
      .wb_rd  (wb_rd),
      .wb_we  (wb_we),
      .sel    (op_sel[g])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  hz_pipe_ctl #(.REG_AW(REG_AW)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_rs1      (id_rs1),
    .id_rs2      (id_rs2),
    .ex_rd       (ex_rd),
    .ex_we       (ex_we),
    .ex_load     (ex_load),
    .ex_redirect (ex_redirect),
    .mem_busy    (mem_busy),
    .pc_en       (pc_en),
    .ifid_en     (ifid_en),
    .pipe_en     (pipe_en),
    .idex_bubble (idex_bubble),
    .ifid_flush  (ifid_flush),
    .idex_flush  (idex_flush)
  );

  hz_trap_gate #(.TRAP_DLY(TRAP_DLY)) u_trap (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_raw (trap_raw),
    .trap_out (trap_out)
  );

  // R9
  reset_trap_chk: assert property (@(posedge clk) !rst_n |-> !trap_out);
  // R2
  wb_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'b10) |-> (wb_we && wb_rd == ex_rs1 && !(mem_we && mem_rd == ex_rs1)));
endmodule

// File: tb/tb_hz_unit.sv
`timescale 1ns/1ps
module tb_hz_unit;
  localparam int AW  = 5;
  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_we, ex_load, mem_we, wb_we, ex_redirect, mem_busy, trap_raw;
  logic [1:0] fwd_a, fwd_b;
  logic pc_en, ifid_en, pipe_en, idex_bubble, ifid_flush, idex_flush, trap_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hz_unit #(.REG_AW(AW), .TRAP_DLY(DLY)) dut (.*);

  function automatic logic [1:0] exp_fwd(logic [AW-1:0] s);
    if (mem_we && mem_rd != 0 && mem_rd == s) return 2'b01;
    if (wb_we && wb_rd != 0 && wb_rd == s)    return 2'b10;
    return 2'b00;
  endfunction

  // {pc_en, ifid_en, pipe_en, idex_bubble, ifid_flush, idex_flush}
  function automatic logic [5:0] exp_ctl();
    logic lu;
    lu = ex_load && ex_we && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    if (mem_busy)    return 6'b000000;
    if (ex_redirect) return 6'b111011;
    if (lu)          return 6'b001100;
    return 6'b111000;
  endfunction

  function automatic string ctl_tag();
    if (mem_busy)    return "R7";
    if (ex_redirect) return "R6";
    if (exp_ctl() == 6'b001100) return "R4";
    return "R5";
  endfunction

  function automatic string fwd_tag(logic [1:0] e);
    if (e == 2'b01) return "R1";
    if (e == 2'b10) return "R2";
    return "R3";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [1:0] ea, eb;
    #1;
    ea = exp_fwd(ex_rs1);
    eb = exp_fwd(ex_rs2);
    chk(fwd_tag(ea), fwd_a, ea);
    chk(fwd_tag(eb), fwd_b, eb);
    chk(ctl_tag(), {pc_en, ifid_en, pipe_en, idex_bubble, ifid_flush, idex_flush}, exp_ctl());
  endtask

  task automatic clear();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    {ex_we, ex_load, mem_we, wb_we, ex_redirect, mem_busy} = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1d5;
    void'($urandom(seed));
    clear();
    trap_raw = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", trap_out, 0);
    rst_n = 1'b1;
    // posedges since release vs mask
    for (int k = 0; k <= DLY + 2; k++) begin
      #1;
      chk("R8", trap_out, (k >= DLY) ? 1 : 0);
      @(negedge clk);
    end
    trap_raw = 1'b0; #1; chk("R8", trap_out, 0);

    // directed: both stages match same source
    @(negedge clk); clear();
    ex_rs1 = 5'd7; ex_rs2 = 5'd7; mem_rd = 5'd7; mem_we = 1; wb_rd = 5'd7; wb_we = 1;
    check_all(); chk("R1", fwd_a, 2'b01);
    // directed: x0 in both stages
    @(negedge clk); clear();
    mem_rd = 0; mem_we = 1; wb_rd = 0; wb_we = 1;
    check_all(); chk("R3", fwd_b, 2'b00);
    // only MEM/WB matches
    @(negedge clk); clear();
    ex_rs2 = 5'd4; wb_rd = 5'd4; wb_we = 1; mem_rd = 5'd5; mem_we = 1;
    check_all(); chk("R2", fwd_b, 2'b10);
    // load to x0 does not stall
    @(negedge clk); clear();
    ex_load = 1; ex_we = 1; ex_rd = 0;
    check_all(); chk("R5", idex_bubble, 0);
    // load-use hazard
    @(negedge clk); clear();
    ex_load = 1; ex_we = 1; ex_rd = 5'd9; id_rs2 = 5'd9;
    check_all(); chk("R4", {pc_en, idex_bubble}, 2'b01);
    // redirect with load-use
    ex_redirect = 1;
    check_all(); chk("R6", {idex_bubble, idex_flush, ifid_flush}, 3'b011);
    // busy during redirect, forwarding still live
    mem_busy = 1; ex_rs1 = 5'd3; mem_rd = 5'd3; mem_we = 1;
    check_all(); chk("R7", {pc_en, ifid_flush, fwd_a}, 4'b0001);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      id_rs1 = AW'($urandom_range(0, 3));
      id_rs2 = AW'($urandom_range(0, 3));
      ex_rs1 = AW'($urandom_range(0, 3));
      ex_rs2 = AW'($urandom_range(0, 3));
      ex_rd  = AW'($urandom_range(0, 3));
      mem_rd = AW'($urandom_range(0, 3));
      wb_rd  = AW'($urandom_range(0, 3));
      ex_we  = 1'($urandom);
      ex_load = 1'($urandom);
      mem_we = 1'($urandom);
      wb_we  = 1'($urandom);
      ex_redirect = ($urandom_range(0, 5) == 0);
      mem_busy    = ($urandom_range(0, 7) == 0);
      trap_raw    = 1'($urandom);
      check_all();
      chk("R8", trap_out, trap_raw);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule